// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block gives a CPU indirect access to PCI configuration space through a host bridge. Software first loads a configuration address register with an enable bit, a bus/device/function selection and a dword register number, then reads or writes a configuration data register. Each data access becomes one 32-bit configuration transaction on a downstream request/response port. A downstream agent behind that port turns the transaction into bus cycles, and that bus signalling is outside this block.

The block also holds the bridge command register. Bit 0 of that register selects the byte order of configuration data. When the bit is clear and the addressed device field is nonzero, data is byte-reversed in both directions. A data access while the enable bit is clear never reaches the downstream port. A read then returns all ones and a write is discarded.

The CPU port is a valid/ready request channel plus a valid/ready response channel. Every accepted request produces exactly one response. The request channel stays stalled (ready low) from acceptance until that response has been taken, so only one access is ever in flight. On the downstream side a request holds valid, address, direction and data steady until ready is seen. A read then waits for a single-cycle response strobe carrying the data.

Top module: `pci_cfg_port`

## Requirements
- R1: Register select code 0 is the configuration address. A write stores the data ANDed with 0x80FFFFFC. A read returns the stored value. The reset value is 0.
- R2: Select code 2 is the command register. A write stores the data ANDed with 0x0401FC0F. A read returns the stored value. The reset value is 0x00010001.
- R3: With address bit 31 set, a write to the data register (select code 1) issues exactly one downstream write. That write carries the stored address and a full 32-bit data word.
- R4: With address bit 31 clear, a data write issues no downstream request and still completes with a response.
- R5: With address bit 31 clear, a data read returns 0xFFFFFFFF and issues no downstream request.
- R6: With address bit 31 set, a data read issues exactly one downstream read at the stored address. It returns the data from the downstream response strobe.
- R7: Data is byte-reversed (byte 0 swapped with byte 3, byte 1 with byte 2) in both directions when command bit 0 is 0 and address bits 23:11 are not all zero. Otherwise data passes unchanged.
- R8: `cpu_req_ready` is low from request acceptance until the response is taken. A downstream request rises only on an accepted CPU request, and it keeps its valid, address, direction and data stable until `dn_req_ready`.
- R9: The CPU response holds valid and data until `cpu_rsp_ready`. Write responses return 0.
- R10: Select code 3 is unmapped. Reads return 0, and writes change neither the address nor the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a CPU request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_sel | input | 2 | 0 address, 1 data, 2 command, 3 unmapped |
| cpu_req_wdata | input | 32 | CPU write data |
| cpu_rsp_valid | output | 1 | CPU response valid |
| cpu_rsp_ready | input | 1 | CPU takes the response |
| cpu_rsp_rdata | output | 32 | Response data |
| dn_req_valid | output | 1 | Downstream configuration request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_write | output | 1 | Downstream direction, 1 = write |
| dn_req_addr | output | 32 | Masked configuration address |
| dn_req_wdata | output | 32 | Write data after byte-order handling |
| dn_rsp_valid | input | 1 | Downstream read data strobe |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that the downstream agent raises `dn_rsp_valid` only for a read it has already accepted, and only once per read. They also assume the CPU keeps its request fields steady while valid is high. The bench responder observes this: it strobes a single response cycle only after completing a read handshake, and it varies the ready and response delays between zero and two cycles. The CPU driver holds each request until acceptance, then drops it. It sweeps both command byte-order settings, both enable values and a walking bit through the device field.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DN_REQ = 2'd1,
    ST_DN_RSP = 2'd2,
    ST_RESP   = 2'd3
  } state_e;

endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] ADDR_MASK = 32'h80FF_FFFC,
  parameter logic [31:0] CMD_MASK  = 32'h0401_FC0F,
  parameter logic [31:0] CMD_RESET = 32'h0001_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr_en,
  input  logic              wr_cmd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] cmd_q
);

  localparam logic [DATA_W-1:0] AMASK = DATA_W'(ADDR_MASK);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(CMD_MASK);
  localparam logic [DATA_W-1:0] CRST  = DATA_W'(CMD_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_addr_en) begin
      addr_q <= wdata & AMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CRST;
    end else if (wr_cmd_en) begin
      cmd_q <= wdata & CMASK;
    end
  end

endmodule

// File: rtl/pcfg_swap.sv
module pcfg_swap #(
  parameter int DATA_W = 32
) (
  input  logic              do_swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int BYTES = DATA_W / 8;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = do_swap ? din[8*(BYTES-1-b) +: 8] : din[8*b +: 8];
  end

endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  sel_e              sel,
  input  logic              fwd_en,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic [DATA_W-1:0] addr_q,
  input  logic              dn_req_ready,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] rx_rdata,
  input  logic              cpu_rsp_ready,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              dn_req_valid,
  output logic              dn_req_write,
  output logic [DATA_W-1:0] dn_req_addr,
  output logic [DATA_W-1:0] dn_req_wdata
);

  state_e            state_q;
  logic [DATA_W-1:0] rsp_q;
  logic              wr_q;
  logic [DATA_W-1:0] addr_cap_q;
  logic [DATA_W-1:0] wdata_cap_q;

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign dn_req_valid  = (state_q == ST_DN_REQ);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_rdata = rsp_q;
  assign dn_req_write  = wr_q;
  assign dn_req_addr   = addr_cap_q;
  assign dn_req_wdata  = wdata_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_q       <= '0;
      wr_q        <= 1'b0;
      addr_cap_q  <= '0;
      wdata_cap_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (sel == SEL_DATA && fwd_en) begin
              wr_q        <= is_write;
              addr_cap_q  <= addr_q;
              wdata_cap_q <= is_write ? tx_wdata : '0;
              state_q     <= ST_DN_REQ;
            end else if (sel == SEL_DATA) begin
              rsp_q   <= is_write ? '0 : '1;
              state_q <= ST_RESP;
            end else begin
              rsp_q   <= is_write ? '0 : reg_rdata;
              state_q <= ST_RESP;
            end
          end
        end
        ST_DN_REQ: begin
          if (dn_req_ready) begin
            if (wr_q) begin
              rsp_q   <= '0;
              state_q <= ST_RESP;
            end else begin
              state_q <= ST_DN_RSP;
            end
          end
        end
        ST_DN_RSP: begin
          if (dn_rsp_valid) begin
            rsp_q   <= rx_rdata;
            state_q <= ST_RESP;
          end
        end
        default: begin
          if (cpu_rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import pcfg_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter logic [31:0] ADDR_MASK    = 32'h80FF_FFFC,
  parameter logic [31:0] CMD_MASK     = 32'h0401_FC0F,
  parameter logic [31:0] CMD_RESET    = 32'h0001_0001,
  parameter int          EN_BIT       = 31,
  parameter int          DEV_LO       = 11,
  parameter int          DEV_HI       = 23,
  parameter int          SWAP_CTL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [1:0]        cpu_req_sel,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [DATA_W-1:0] dn_req_addr,
  output logic [DATA_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata
);

  sel_e              sel;
  logic              accept;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] tx_wdata;
  logic [DATA_W-1:0] rx_rdata;
  logic              need_swap;

  assign sel       = sel_e'(cpu_req_sel);
  assign accept    = cpu_req_valid && cpu_req_ready;
  assign need_swap = !cmd_q[SWAP_CTL_BIT] && (|addr_q[DEV_HI:DEV_LO]);

  always_comb begin
    case (sel)
      SEL_ADDR: reg_rdata = addr_q;
      SEL_CMD:  reg_rdata = cmd_q;
      default:  reg_rdata = '0;
    endcase
  end

  pcfg_regs #(
    .DATA_W   (DATA_W),
    .ADDR_MASK(ADDR_MASK),
    .CMD_MASK (CMD_MASK),
    .CMD_RESET(CMD_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_addr_en(accept && cpu_req_write && sel == SEL_ADDR),
    .wr_cmd_en (accept && cpu_req_write && sel == SEL_CMD),
    .wdata     (cpu_req_wdata),
    .addr_q    (addr_q),
    .cmd_q     (cmd_q)
  );

  pcfg_swap #(.DATA_W(DATA_W)) u_swap_tx (
    .do_swap(need_swap),
    .din    (cpu_req_wdata),
    .dout   (tx_wdata)
  );

  pcfg_swap #(.DATA_W(DATA_W)) u_swap_rx (
    .do_swap(need_swap),
    .din    (dn_rsp_rdata),
    .dout   (rx_rdata)
  );

  pcfg_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .is_write     (cpu_req_write),
    .sel          (sel),
    .fwd_en       (addr_q[EN_BIT]),
    .reg_rdata    (reg_rdata),
    .tx_wdata     (tx_wdata),
    .addr_q       (addr_q),
    .dn_req_ready (dn_req_ready),
    .dn_rsp_valid (dn_rsp_valid),
    .rx_rdata     (rx_rdata),
    .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_req_ready(cpu_req_ready),
    .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .dn_req_valid (dn_req_valid),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_wdata (dn_req_wdata)
  );

endmodule

// File: rtl/pci_cfg_port_chk.sv
module pci_cfg_port_chk #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] ADDR_MASK = 32'h80FF_FFFC,
  parameter int          EN_BIT    = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic              dn_req_write,
  input logic [DATA_W-1:0] dn_req_addr,
  input logic [DATA_W-1:0] dn_req_wdata
);

  localparam logic [DATA_W-1:0] AMASK = DATA_W'(ADDR_MASK);

  AST_DN_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
      && $stable(dn_req_write) && $stable(dn_req_wdata)); // R8

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || cpu_rsp_valid) |-> !cpu_req_ready); // R8

  AST_DN_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req_valid) |-> $past(cpu_req_valid && cpu_req_ready)); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)); // R9

  AST_DN_ENABLED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> dn_req_addr[EN_BIT] && ((dn_req_addr & ~AMASK) == '0)); // R3

endmodule

bind pci_cfg_port pci_cfg_port_chk #(
  .DATA_W   (DATA_W),
  .ADDR_MASK(ADDR_MASK),
  .EN_BIT   (EN_BIT)
) i_chk (.*);

// File: tb/test_pci_cfg_port.sv
module test_pci_cfg_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [1:0]  cpu_req_sel = 2'd0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_rdata;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic        dn_req_write;
  logic [31:0] dn_req_addr;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int errors = 0;
  int checks = 0;
  int dn_count = 0;
  logic        last_write;
  logic [31:0] last_addr;
  logic [31:0] last_wdata;
  int req_delay = 0;
  int rsp_delay = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_port i_pci_cfg_port (.*);

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] dev_model(input logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_access(input logic wr, input logic [1:0] sel, input logic [31:0] wd,
                            input int hold, output logic [31:0] rd);
    logic [31:0] held;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_sel   = sel;
    cpu_req_wdata = wd;
    cpu_rsp_ready = (hold == 0);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check("R8 stall after accept", 32'(cpu_req_ready), 32'd0);
    while (!cpu_rsp_valid) @(negedge clk);
    if (hold > 0) begin
      held = cpu_rsp_rdata;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check("R9 response held", {31'd0, cpu_rsp_valid}, 32'd1);
        check("R9 response data stable", cpu_rsp_rdata, held);
      end
      cpu_rsp_ready = 1'b1;
    end
    rd = cpu_rsp_rdata;
    @(negedge clk);
  endtask

  // downstream responder
  initial begin
    logic        is_rd;
    logic [31:0] a;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      dn_req_ready = 1'b0;
      dn_rsp_valid = 1'b0;
      if (dn_req_valid) begin
        repeat (req_delay) @(negedge clk);
        dn_req_ready = 1'b1;
        dn_count++;
        last_write = dn_req_write;
        last_addr  = dn_req_addr;
        last_wdata = dn_req_wdata;
        is_rd = !dn_req_write;
        a = dn_req_addr;
        @(negedge clk);
        dn_req_ready = 1'b0;
        if (is_rd) begin
          repeat (rsp_delay) @(negedge clk);
          dn_rsp_valid = 1'b1;
          dn_rsp_rdata = dev_model(a);
          @(negedge clk);
          dn_rsp_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] aw;
    logic [31:0] exp_a;
    logic [31:0] wd;
    logic [31:0] cmdw;
    logic [12:0] field;
    logic        sw;
    int          n0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset cpu_req_ready", {31'd0, cpu_req_ready}, 32'd1);
    check("reset dn_req_valid", {31'd0, dn_req_valid}, 32'd0);
    check("reset cpu_rsp_valid", {31'd0, cpu_rsp_valid}, 32'd0);
    cpu_access(1'b0, 2'd0, '0, 0, rd);
    check("R1 address reset", rd, 32'h0);
    cpu_access(1'b0, 2'd2, '0, 0, rd);
    check("R2 command reset", rd, 32'h0001_0001);

    // R5: disabled read at reset-state address
    n0 = dn_count;
    cpu_access(1'b0, 2'd1, '0, 0, rd);
    check("R5 disabled read data", rd, 32'hFFFF_FFFF);
    check("R5 no downstream request", 32'(dn_count), 32'(n0));

    // R9: held responses and zero write response
    cpu_access(1'b1, 2'd0, 32'h8000_0804, 3, rd);
    check("R9 write response zero", rd, 32'h0);
    cpu_access(1'b0, 2'd0, '0, 2, rd);
    check("R1 held read", rd, 32'h8000_0804);

    for (int c = 0; c < 2; c++) begin
      cmdw = (c == 1) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE;
      cpu_access(1'b1, 2'd2, cmdw, 0, rd);
      cpu_access(1'b0, 2'd2, '0, 0, rd);
      check("R2 command mask", rd, cmdw & 32'h0401_FC0F);
      for (int i = 0; i < 14; i++) begin
        for (int en = 0; en < 2; en++) begin
          field = (i == 0) ? 13'd0 : 13'(1 << (i - 1));
          aw = {en[0], 7'h55, field, 11'((i * 37) | 3)};
          exp_a = aw & 32'h80FF_FFFC;
          cpu_access(1'b1, 2'd0, aw, 0, rd);
          cpu_access(1'b0, 2'd0, '0, 0, rd);
          check("R1 address mask", rd, exp_a);
          sw = (c == 0) && (field != 13'd0);
          req_delay = i % 3;
          rsp_delay = (i + en) % 3;
          wd = 32'h1357_9BDF ^ (32'(i) * 32'h0102_0408);
          n0 = dn_count;
          cpu_access(1'b1, 2'd1, wd, 0, rd);
          if (en == 1) begin
            check("R3 one downstream write", 32'(dn_count), 32'(n0 + 1));
            check("R3 direction write", {31'd0, last_write}, 32'd1);
            check("R3 write address", last_addr, exp_a);
            check("R7 write data order", last_wdata, sw ? bswap(wd) : wd);
          end else begin
            check("R4 dropped write", 32'(dn_count), 32'(n0));
          end
          check("R9 data write response", rd, 32'h0);
          n0 = dn_count;
          cpu_access(1'b0, 2'd1, '0, 0, rd);
          if (en == 1) begin
            check("R6 one downstream read", 32'(dn_count), 32'(n0 + 1));
            check("R6 direction read", {31'd0, last_write}, 32'd0);
            check("R6 read address", last_addr, exp_a);
            check("R7 read data order", rd,
                  sw ? bswap(dev_model(exp_a)) : dev_model(exp_a));
          end else begin
            check("R5 disabled read data", rd, 32'hFFFF_FFFF);
            check("R5 no downstream request", 32'(dn_count), 32'(n0));
          end
        end
      end
    end

    // R10: unmapped select
    cpu_access(1'b1, 2'd0, 32'h8012_3456, 0, rd);
    cpu_access(1'b1, 2'd3, 32'hFFFF_FFFF, 0, rd);
    cpu_access(1'b0, 2'd3, '0, 0, rd);
    check("R10 unmapped read", rd, 32'h0);
    cpu_access(1'b0, 2'd0, '0, 0, rd);
    check("R10 address untouched", rd, 32'h8012_3454);
    cpu_access(1'b0, 2'd2, '0, 0, rd);
    check("R10 command untouched", rd, 32'h0401_FC0F);

    // R8: long downstream stall
    req_delay = 5;
    rsp_delay = 4;
    cpu_access(1'b0, 2'd1, '0, 0, rd);
    check("R8 read after long stall", rd, dev_model(32'h8012_3454));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule